// File: doc/BRIEF.md
# Control-Register Bus to MAC Host-Bus Bridge

This block sits between a processor's simple control-register bus and the host bus of an Ethernet MAC. The processor sees four word-wide registers: two data words, a command register and a ready-status register. Writing the command register starts one host-bus transaction. The bridge drives the host address, opcode, write data and enable strobe, and for reads it captures the returned beats into the data words.

The host address space falls into four access classes: configuration, statistics, MII management and address filter. Each class owns one bit of the ready-status register. That bit drops while an access of its class is in flight and returns when the access completes. Software either polls the status register or sets an interrupt-enable bit in the command word, so that a one-cycle interrupt pulse marks completion.

Top module: `crb_host_bridge`

## Requirements
- R1: Processor register offsets: 0 is the high data word, 1 is the low data word, 2 is the command register and 3 is the ready-status register. A read of offset 2 returns the last accepted command word masked with 0x0001_83FF. A read of offset 3 returns the four ready bits in bits [3:0], with zeros above them.
- R2: After reset, status reads 0xF, both data words and the command register read 0, the host enable is low, the host opcode is 00 and the interrupt is low.
- R3: The command word is decoded as follows: bits [9:0] give the host address, bit 15 = 1 requests a write and 0 a read, and bit 16 enables the interrupt. The host address selects the class: below 0x200 is statistics (status bit 1), 0x200–0x33F is configuration (bit 0), 0x340–0x37F is MII management (bit 2) and 0x380–0x3FF is address filter (bit 3). Accepting a command clears that class's ready bit from the next cycle, and no other bit changes.
- R4: While an access is in flight, the host address holds the command address and the host opcode is 10 for a read and 01 for a write; it is 00 when idle. The host write data is the low data word. Statistics accesses are always reads. The enable is high for one cycle per beat: two beats for statistics and address-filter reads, one beat otherwise. An MII management access pulses the enable once and then waits for the host ready input.
- R5: Host read data for a beat is valid in the cycle after that beat's enable cycle. The first beat goes into the low data word and the second into the high data word. A single-beat read leaves the high word unchanged. An MII read captures the host data in the cycle the host ready input is high. Writes change neither data word.
- R6: The ready bit returns to 1 one cycle after the final capture cycle. If the command is accepted at the end of cycle 0, status shows ready again in cycle 3 for writes and configuration reads, in cycle 4 for two-beat reads, and in cycle 2+L for an MII access whose ready arrives L cycles after its enable.
- R7: When the accepted command had bit 16 set, the interrupt is high for exactly the one cycle in which the ready bit returns. When bit 16 was clear, the interrupt stays low.
- R8: While an access is in flight, processor writes to any register (command or data) are ignored. They start no access and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Processor register access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_off | input | 2 | Register offset |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, same cycle as strobe |
| cpu_irq | output | 1 | Completion interrupt pulse |
| h_addr | output | 10 | Host-bus register address |
| h_opcode | output | 2 | Host opcode: 10 read, 01 write, 00 idle |
| h_wdata | output | 32 | Host write data |
| h_en | output | 1 | Host enable, one cycle per beat |
| h_rdata | input | 32 | Host read data |
| h_mii_rdy | input | 1 | MII management completion from host |

## Verification
The hardest situations to reach from the ports are a second command, or a data-word write, landing in the cycles while a multi-beat or MII access is still in flight. Only a processor that writes immediately after the start can hit them. For every eighth address, the bench issues a conflicting command in the first cycle after the start and overwrites the low word in the second. It then checks that the host saw only the first address, that captured data and write data are untouched, and that exactly one completion occurs. A host model with an MII latency that varies by address supplies per-beat data derived from the address. The bench sweeps the whole 10-bit address space for both reads and writes, so every class and beat count is covered.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int DATA_W    = 32;
    localparam int HADDR_W   = 10;
    localparam int N_CLASS   = 4;
    localparam int OFF_W     = 2;
    localparam int CNT_W     = 2;
    localparam int MULTI_BEATS = 2;

    // command word fields
    localparam int CTL_WR_BIT = 15;
    localparam int CTL_IE_BIT = 16;
    localparam logic [DATA_W-1:0] CTL_MASK =
        (DATA_W'(1) << CTL_IE_BIT) | (DATA_W'(1) << CTL_WR_BIT) | DATA_W'((1 << HADDR_W) - 1);

    // host address map boundaries
    localparam logic [HADDR_W-1:0] CFG_BASE = 10'h200;
    localparam logic [HADDR_W-1:0] MII_BASE = 10'h340;
    localparam logic [HADDR_W-1:0] AF_BASE  = 10'h380;

    // host opcodes
    localparam logic [1:0] HOP_IDLE = 2'b00;
    localparam logic [1:0] HOP_WR   = 2'b01;
    localparam logic [1:0] HOP_RD   = 2'b10;

    typedef enum logic [1:0] {
        CLS_CFG  = 2'd0,
        CLS_STAT = 2'd1,
        CLS_MII  = 2'd2,
        CLS_AF   = 2'd3
    } acc_cls_e;

    typedef enum logic [OFF_W-1:0] {
        OFF_HI  = 2'd0,
        OFF_LO  = 2'd1,
        OFF_CTL = 2'd2,
        OFF_STS = 2'd3
    } reg_off_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic [HADDR_W-1:0] addr;
        logic               rnw;
        logic               irq_en;
        acc_cls_e           cls;
    } cmd_t;

    function automatic acc_cls_e classify(input logic [HADDR_W-1:0] a);
        if (a < CFG_BASE)      return CLS_STAT;
        else if (a < MII_BASE) return CLS_CFG;
        else if (a < AF_BASE)  return CLS_MII;
        else                   return CLS_AF;
    endfunction

    function automatic cmd_t decode_ctl(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.addr   = w[HADDR_W-1:0];
        c.cls    = classify(c.addr);
        c.rnw    = !w[CTL_WR_BIT] || (c.cls == CLS_STAT);
        c.irq_en = w[CTL_IE_BIT];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] beats_of(input cmd_t c);
        if (c.rnw && (c.cls == CLS_STAT || c.cls == CLS_AF))
            return CNT_W'(MULTI_BEATS);
        else
            return CNT_W'(1);
    endfunction

endpackage

// File: rtl/crb_regs.sv
module crb_regs
    import crb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sel,
    input  logic                   we,
    input  reg_off_e               off,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   busy,
    input  logic                   cap_lo,
    input  logic                   cap_hi,
    input  logic [DATA_W-1:0]      cap_data,
    input  logic [N_CLASS-1:0]     rdy,
    output logic [DATA_W-1:0]      rdata,
    output logic [DATA_W-1:0]      lo_q,
    output logic                   start,
    output cmd_t                   cmd
);

    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] ctl_q;
    logic              wr_hit;

    assign wr_hit = sel && we && !busy;
    assign start  = wr_hit && (off == OFF_CTL);
    assign cmd    = decode_ctl(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            hi_q  <= '0;
            ctl_q <= '0;
        end else begin
            if (cap_lo)
                lo_q <= cap_data;
            else if (wr_hit && off == OFF_LO)
                lo_q <= wdata;

            if (cap_hi)
                hi_q <= cap_data;
            else if (wr_hit && off == OFF_HI)
                hi_q <= wdata;

            if (start)
                ctl_q <= wdata & CTL_MASK;
        end
    end

    always_comb begin
        unique case (off)
            OFF_HI:  rdata = hi_q;
            OFF_LO:  rdata = lo_q;
            OFF_CTL: rdata = ctl_q;
            OFF_STS: rdata = {{(DATA_W-N_CLASS){1'b0}}, rdy};
            default: rdata = '0;
        endcase
    end

    // R8: writes during an access leave the command register alone
    p_ctl_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && sel && we) |=> $stable(ctl_q));

    // R8: a data write during an access does not reach the high word
    p_hi_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !cap_hi) |=> $stable(hi_q));

endmodule

// File: rtl/crb_seq.sv
module crb_seq
    import crb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  cmd_t                 cmd,
    input  logic                 h_mii_rdy,
    output logic                 h_en,
    output logic [1:0]           h_opcode,
    output logic [HADDR_W-1:0]   h_addr,
    output logic                 cap_lo,
    output logic                 cap_hi,
    output logic                 done,
    output logic                 busy,
    output acc_cls_e             cls,
    output logic                 irq_en
);

    seq_st_e           st_q;
    cmd_t              cmd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  nb;
    logic              is_mii;
    logic              mii_hit;

    assign busy    = (st_q == SEQ_RUN);
    assign is_mii  = (cmd_q.cls == CLS_MII);
    assign nb      = beats_of(cmd_q);
    assign mii_hit = busy && is_mii && (cnt_q != '0) && h_mii_rdy;
    assign cls     = cmd_q.cls;
    assign irq_en  = cmd_q.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            cmd_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                SEQ_IDLE: begin
                    if (start) begin
                        st_q  <= SEQ_RUN;
                        cmd_q <= cmd;
                        cnt_q <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (done)
                        st_q <= SEQ_IDLE;
                    else if (cnt_q != '1)
                        cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        h_en     = 1'b0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        done     = 1'b0;
        h_opcode = HOP_IDLE;
        h_addr   = '0;
        if (busy) begin
            h_opcode = cmd_q.rnw ? HOP_RD : HOP_WR;
            h_addr   = cmd_q.addr;
            if (is_mii) begin
                h_en   = (cnt_q == '0);
                cap_lo = mii_hit && cmd_q.rnw;
                done   = mii_hit;
            end else begin
                h_en   = (cnt_q < nb);
                cap_lo = cmd_q.rnw && (cnt_q == CNT_W'(1));
                cap_hi = cmd_q.rnw && (nb == CNT_W'(MULTI_BEATS))
                         && (cnt_q == CNT_W'(MULTI_BEATS));
                done   = (cnt_q == nb);
            end
        end
    end

    // R3: an accepted command drives its first beat on the next cycle
    p_first_beat_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> (h_en && busy));

    // R4: statistics accesses never carry the write opcode
    p_stat_read_r4: assert property (@(posedge clk) disable iff (rst)
        (h_en && h_addr < CFG_BASE) |-> (h_opcode == HOP_RD));

    // R4: enable only appears with a live opcode
    p_en_opcode_r4: assert property (@(posedge clk) disable iff (rst)
        h_en |-> (h_opcode != HOP_IDLE));

    // R8: address held steady until the access completes
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && $stable(h_addr) && $stable(h_opcode)));

endmodule

// File: rtl/crb_status.sv
module crb_status
    import crb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    input  acc_cls_e           cls,
    input  logic               done,
    input  logic               irq_en,
    output logic [N_CLASS-1:0] rdy,
    output logic               irq
);

    logic irq_q;

    always_comb begin
        rdy = '1;
        if (busy)
            rdy[cls] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= done && irq_en;
    end

    assign irq = irq_q;

    // R3: at most one class shows not-ready
    p_rdy_single_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~rdy));

    // R7: the interrupt is a single-cycle pulse
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: rtl/crb_host_bridge.sv
module crb_host_bridge
    import crb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_sel,
    input  logic                 cpu_we,
    input  logic [OFF_W-1:0]     cpu_off,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 cpu_irq,
    output logic [HADDR_W-1:0]   h_addr,
    output logic [1:0]           h_opcode,
    output logic [DATA_W-1:0]    h_wdata,
    output logic                 h_en,
    input  logic [DATA_W-1:0]    h_rdata,
    input  logic                 h_mii_rdy
);

    logic               start;
    cmd_t               cmd;
    logic               busy;
    logic               done;
    logic               cap_lo;
    logic               cap_hi;
    acc_cls_e           cls;
    logic               irq_en;
    logic [N_CLASS-1:0] rdy;
    logic [DATA_W-1:0]  lo_q;

    crb_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (cpu_sel),
        .we       (cpu_we),
        .off      (reg_off_e'(cpu_off)),
        .wdata    (cpu_wdata),
        .busy     (busy),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .cap_data (h_rdata),
        .rdy      (rdy),
        .rdata    (cpu_rdata),
        .lo_q     (lo_q),
        .start    (start),
        .cmd      (cmd)
    );

    crb_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (cmd),
        .h_mii_rdy (h_mii_rdy),
        .h_en      (h_en),
        .h_opcode  (h_opcode),
        .h_addr    (h_addr),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .done      (done),
        .busy      (busy),
        .cls       (cls),
        .irq_en    (irq_en)
    );

    crb_status u_status (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .cls    (cls),
        .done   (done),
        .irq_en (irq_en),
        .rdy    (rdy),
        .irq    (cpu_irq)
    );

    assign h_wdata = lo_q;

    // R6/R7: an interrupt coincides with the return of the ready bit
    p_irq_ready_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (rdy == '1 && $past(rdy) != '1));

    // R2: no host enable while every class is ready
    p_en_busy_r2: assert property (@(posedge clk) disable iff (rst)
        h_en |-> (rdy != '1));

endmodule

// File: tb/test_crb_host_bridge.sv
`timescale 1ns/1ps
module test_crb_host_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_sel = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_off = 2'd0;
    logic [31:0] cpu_wdata = 32'd0;
    logic [31:0] cpu_rdata;
    logic        cpu_irq;
    logic [9:0]  h_addr;
    logic [1:0]  h_opcode;
    logic [31:0] h_wdata;
    logic        h_en;
    logic [31:0] h_rdata = 32'h0BAD0BAD;
    logic        h_mii_rdy = 1'b0;

    always #2 clk = ~clk;

    crb_host_bridge i_crb_host_bridge (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_off(cpu_off), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_irq(cpu_irq), .h_addr(h_addr), .h_opcode(h_opcode),
        .h_wdata(h_wdata), .h_en(h_en), .h_rdata(h_rdata), .h_mii_rdy(h_mii_rdy)
    );

    int vectors = 0;
    int fails   = 0;
    logic irq_s;

    // host model state
    int          mii_lat = 1;
    int          mii_cnt = 0;
    logic [9:0]  mii_addr = '0;
    logic        prev_en = 1'b0;
    int          prev_beat = 0;
    logic [9:0]  prev_addr = '0;
    logic        prev_mii = 1'b0;
    int          en_cnt = 0;
    logic [9:0]  last_addr = '0;
    logic [1:0]  last_op = '0;
    logic [31:0] last_wdata = '0;
    int          irq_total = 0;

    function automatic int cls_of(input logic [9:0] a);
        if (a < 10'h200) return 1;
        else if (a < 10'h340) return 0;
        else if (a < 10'h380) return 2;
        else return 3;
    endfunction

    function automatic logic [31:0] resp(input logic [9:0] a, input int beat);
        if (beat == 0) return {8'hA5, 14'd0, a};
        else           return {8'h5A, 6'd0, a, 8'h01};
    endfunction

    function automatic logic [31:0] mii_val(input logic [9:0] a);
        return {16'hC0DE, 6'd0, a};
    endfunction

    always @(negedge clk) begin
        int beat;
        h_mii_rdy = 1'b0;
        h_rdata   = 32'h0BAD0BAD;
        if (prev_en && !prev_mii)
            h_rdata = resp(prev_addr, prev_beat);
        if (mii_cnt > 0) begin
            mii_cnt = mii_cnt - 1;
            if (mii_cnt == 0) begin
                h_mii_rdy = 1'b1;
                h_rdata   = mii_val(mii_addr);
            end
        end
        beat = 0;
        if (h_en) begin
            beat = prev_en ? prev_beat + 1 : 0;
            en_cnt     = en_cnt + 1;
            last_addr  = h_addr;
            last_op    = h_opcode;
            last_wdata = h_wdata;
            if (cls_of(h_addr) == 2) begin
                mii_cnt  = mii_lat;
                mii_addr = h_addr;
            end
        end
        if (cpu_irq) irq_total = irq_total + 1;
        prev_en   = h_en;
        prev_beat = beat;
        prev_addr = h_addr;
        prev_mii  = (cls_of(h_addr) == 2);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [1:0] o, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_off = o; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] o, output logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_off = o;
        #1;
        d = cpu_rdata;
        irq_s = cpu_irq;
        @(posedge clk); #1;
        cpu_sel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state
        cpu_rd(2'd3, d); chk("R2 status after reset", d, 32'hF);
        chk("R2 irq after reset", {31'd0, irq_s}, 32'd0);
        chk("R2 h_en after reset", {31'd0, h_en}, 32'd0);
        chk("R2 opcode after reset", {30'd0, h_opcode}, 32'd0);
        cpu_rd(2'd0, d); chk("R2 high word after reset", d, 32'd0);
        cpu_rd(2'd1, d); chk("R2 low word after reset", d, 32'd0);
        cpu_rd(2'd2, d); chk("R2 command after reset", d, 32'd0);

        for (int a = 0; a < 1024; a++) begin
            for (int w = 0; w < 2; w++) begin
                logic [9:0]  ad;
                logic [31:0] pre_hi, pre_lo, ctl, exp_hi, exp_lo, exp_sts;
                int c, nb, exp_k, k0, irq_before;
                logic rd, ie, variant;
                ad      = a[9:0];
                c       = cls_of(ad);
                ie      = ad[0] ^ w[0];
                rd      = (w == 0) || (c == 1);
                variant = (a % 8 == 3);
                mii_lat = 1 + (a % 4);
                nb      = (rd && (c == 1 || c == 3)) ? 2 : 1;
                exp_k   = (c == 2) ? 2 + mii_lat : 2 + nb;
                pre_hi  = 32'h1111_0000 | a;
                pre_lo  = 32'h2222_0000 | a;
                ctl     = ({31'd0, ie} << 16) | (w[0] ? 32'h8000 : 32'h0) | {22'd0, ad};
                exp_sts = 32'hF & ~(32'd1 << c);

                cpu_wr(2'd0, pre_hi);
                cpu_wr(2'd1, pre_lo);
                en_cnt = 0;
                irq_before = irq_total;
                cpu_wr(2'd2, ctl);
                k0 = 1;
                if (variant) begin
                    // R8 conflicting writes during the access
                    cpu_wr(2'd2, 32'h0001_8000 | {22'd0, ~ad});
                    cpu_wr(2'd1, 32'hDEAD_0000);
                    k0 = 3;
                end
                for (int k = k0; k <= exp_k; k++) begin
                    cpu_rd(2'd3, d);
                    if (k < exp_k) begin
                        chk("R3 ready bit low in flight", d, exp_sts);
                        chk("R7 no irq in flight", {31'd0, irq_s}, 32'd0);
                    end else begin
                        chk("R6 ready returns on time", d, 32'hF);
                        chk("R7 irq with ready", {31'd0, irq_s}, {31'd0, ie});
                    end
                end
                chk("R7 irq count", irq_total - irq_before, {31'd0, ie});
                chk("R4 enable beats", en_cnt, (c == 2) ? 1 : nb);
                chk("R4 host address", {22'd0, last_addr}, {22'd0, ad});
                chk("R4 opcode", {30'd0, last_op}, rd ? 32'd2 : 32'd1);
                if (!rd) chk("R4 write data", last_wdata, pre_lo);

                exp_hi = pre_hi;
                exp_lo = pre_lo;
                if (rd) begin
                    if (c == 2) exp_lo = mii_val(ad);
                    else begin
                        exp_lo = resp(ad, 0);
                        if (nb == 2) exp_hi = resp(ad, 1);
                    end
                end
                cpu_rd(2'd1, d); chk("R5 low word", d, exp_lo);
                cpu_rd(2'd0, d); chk("R5 high word", d, exp_hi);
                cpu_rd(2'd2, d); chk("R1 command readback", d, ctl & 32'h0001_83FF);
                if (variant) chk("R8 ignored command", irq_total - irq_before, {31'd0, ie});
            end
        end

        cpu_rd(2'd3, d); chk("R1 idle status", d, 32'hF);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule